// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Decoder

Every processor node carries one copy of this decoder in its local interrupt controller. For each interprocessor interrupt message on the shared interrupt fabric, the decoder decides whether this node is a target. It also flags whether the node may take part in lowest-priority arbitration, and whether the command is an illegal combination. The message provides a destination mode bit, an 8-bit destination field, a 2-bit shorthand, a 3-bit delivery mode, a level bit and the sender's ID. The node provides its own ID, its logical ID and the model field of its format register.

The decision is registered. A two-state machine moves from `ST_IDLE` to `ST_REPORT` on a message strobe, stays in `ST_REPORT` while strobes keep arriving back to back, and returns to `ST_IDLE` on the first cycle without a strobe. The flags are driven only in `ST_REPORT`, so each one is a single-cycle pulse that appears one clock after its strobe. The arbitration itself, the transport and delivery into the core belong to other blocks.

Top module: `ipi_dest_decoder`

## Requirements
- R1: The flags `accept`, `lowpri_ok` and `cmd_err` are 0 during and after reset. Each strobe produces its result on the clock edge that follows it. In any cycle whose previous cycle had no strobe, all three flags are 0.
- R2: When shorthand is 00 and `dest_mode` is 0 (physical), the node accepts if `dest_field` equals `node_id` or equals 8'hFF (broadcast).
- R3: When shorthand is 00, `dest_mode` is 1 and `fmt_model` is 4'b1111 (flat), the node accepts if `dest_field & logical_id` is nonzero.
- R4: When shorthand is 00, `dest_mode` is 1 and `fmt_model` is 4'b0000 (cluster), the node accepts if the upper nibbles are equal and the lower nibbles share a set bit. Any other `fmt_model` value accepts nothing in logical mode.
- R5: Shorthand 01 (self) accepts only when `sender_id` equals `node_id`. The destination mode and destination field are ignored.
- R6: Shorthand 10 (all including self) accepts on every node, whatever the destination mode and destination field.
- R7: Shorthand 11 (all excluding self) accepts on every node except the one whose `node_id` equals `sender_id`.
- R8: Delivery mode INIT (3'b101) with `level` 0 is a valid deassert message. Any other delivery mode with `level` 0 is invalid.
- R9: Shorthand 11 combined with SMI (3'b010) or Start-Up (3'b110) is invalid. Those modes remain valid with the other shorthands.
- R10: Delivery mode codes 3'b011 and 3'b111 are reserved and always invalid. The valid codes are fixed 000, lowest priority 001, SMI 010, NMI 100, INIT 101 and Start-Up 110.
- R11: `lowpri_ok` is 1 when the message is accepted and its delivery mode is lowest priority (3'b001). With parameter `LOWPRI_SEND_OK` set to 0, a lowest-priority message is invalid.
- R12: An invalid message raises `cmd_err` and forces `accept` and `lowpri_ok` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | One-cycle strobe: message fields are valid |
| dest_mode | input | 1 | 0 physical, 1 logical |
| dest_field | input | 8 | Destination ID or logical address |
| shorthand | input | 2 | 00 field, 01 self, 10 all, 11 all but self |
| deliv_mode | input | 3 | Delivery mode code |
| level | input | 1 | Level bit of the command |
| sender_id | input | 8 | ID of the sending node |
| node_id | input | 8 | This node's ID |
| logical_id | input | 8 | This node's logical ID |
| fmt_model | input | 4 | Logical model select, flat or cluster |
| accept | output | 1 | Message targets this node |
| lowpri_ok | output | 1 | Node eligible for lowest-priority arbitration |
| cmd_err | output | 1 | Illegal command combination |

## Verification
The bench targets the edges of each matching rule:
- Broadcast ID 8'hFF, against a decoder that only compares for equality.
- A cluster address whose lower nibble overlaps the logical ID but whose upper nibble differs. A cluster match that skipped the nibble compare would accept it.
- An undefined format model with all-ones fields, which a loose flat/cluster decode would wrongly accept.
- The self and all-but-self shorthands, once with a sender equal to the node and once with a different sender. This exposes a swapped or inverted identity compare.
- The command checks: INIT versus other modes with the level bit at 0, SMI and Start-Up under each broadcast shorthand, both reserved codes, and a lowest-priority message on a node built without permission to send one. A design that lets an error through would show `accept` and `cmd_err` high together.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;

    typedef enum logic [1:0] {
        SH_NONE   = 2'b00,
        SH_SELF   = 2'b01,
        SH_ALL    = 2'b10,
        SH_OTHERS = 2'b11
    } shorthand_t;

    typedef enum logic [2:0] {
        DM_FIXED   = 3'b000,
        DM_LOWPRI  = 3'b001,
        DM_SMI     = 3'b010,
        DM_RSV3    = 3'b011,
        DM_NMI     = 3'b100,
        DM_INIT    = 3'b101,
        DM_STARTUP = 3'b110,
        DM_RSV7    = 3'b111
    } deliv_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } dec_state_t;

    localparam logic [3:0] MODEL_FLAT    = 4'b1111;
    localparam logic [3:0] MODEL_CLUSTER = 4'b0000;

endpackage

// File: rtl/ipi_addr_match.sv
module ipi_addr_match
    import ipi_dest_pkg::*;
#(
    parameter int ID_W    = 8,
    parameter int MODEL_W = 4
) (
    input  logic               dest_mode,
    input  logic [ID_W-1:0]    dest_field,
    input  logic [1:0]         shorthand,
    input  logic [ID_W-1:0]    sender_id,
    input  logic [ID_W-1:0]    node_id,
    input  logic [ID_W-1:0]    logical_id,
    input  logic [MODEL_W-1:0] fmt_model,
    output logic               hit
);
    localparam int              HALF_W    = ID_W / 2;
    localparam logic [ID_W-1:0] BCAST_ID  = {ID_W{1'b1}};

    logic is_self;
    logic phys_hit;
    logic flat_hit;
    logic clus_hit;
    logic logic_hit;

    assign is_self  = (sender_id == node_id);
    assign phys_hit = (dest_field == node_id) || (dest_field == BCAST_ID);
    assign flat_hit = |(dest_field & logical_id);
    assign clus_hit = (dest_field[ID_W-1:HALF_W] == logical_id[ID_W-1:HALF_W]) &&
                      (|(dest_field[HALF_W-1:0] & logical_id[HALF_W-1:0]));

    always_comb begin
        if (fmt_model == MODEL_FLAT[MODEL_W-1:0])
            logic_hit = flat_hit;
        else if (fmt_model == MODEL_CLUSTER[MODEL_W-1:0])
            logic_hit = clus_hit;
        else
            logic_hit = 1'b0;
    end

    always_comb begin
        unique case (shorthand_t'(shorthand))
            SH_NONE:   hit = dest_mode ? logic_hit : phys_hit;
            SH_SELF:   hit = is_self;
            SH_ALL:    hit = 1'b1;
            SH_OTHERS: hit = !is_self;
        endcase
    end

endmodule

// File: rtl/ipi_cmd_check.sv
module ipi_cmd_check
    import ipi_dest_pkg::*;
#(
    parameter bit LOWPRI_SEND_OK = 1'b1
) (
    input  logic [1:0] shorthand,
    input  logic [2:0] deliv_mode,
    input  logic       level,
    output logic       bad,
    output logic       is_lowpri
);
    logic level_bad;
    logic mode_bad;

    always_comb begin
        mode_bad  = 1'b0;
        level_bad = !level;
        is_lowpri = 1'b0;
        unique case (deliv_t'(deliv_mode))
            DM_FIXED, DM_NMI: ;
            DM_LOWPRI: begin
                is_lowpri = 1'b1;
                mode_bad  = !LOWPRI_SEND_OK;
            end
            DM_SMI, DM_STARTUP: mode_bad = (shorthand == SH_OTHERS);
            DM_INIT:            level_bad = 1'b0;
            DM_RSV3, DM_RSV7:   mode_bad  = 1'b1;
        endcase
    end

    assign bad = mode_bad || level_bad;

endmodule

// File: rtl/ipi_dest_decoder.sv
module ipi_dest_decoder
    import ipi_dest_pkg::*;
#(
    parameter int ID_W           = 8,
    parameter int MODEL_W        = 4,
    parameter bit LOWPRI_SEND_OK = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_valid,
    input  logic               dest_mode,
    input  logic [ID_W-1:0]    dest_field,
    input  logic [1:0]         shorthand,
    input  logic [2:0]         deliv_mode,
    input  logic               level,
    input  logic [ID_W-1:0]    sender_id,
    input  logic [ID_W-1:0]    node_id,
    input  logic [ID_W-1:0]    logical_id,
    input  logic [MODEL_W-1:0] fmt_model,
    output logic               accept,
    output logic               lowpri_ok,
    output logic               cmd_err
);
    dec_state_t state_q, state_d;
    logic       hit, bad, is_lowpri;
    logic       acc_q, lp_q, err_q;

    ipi_addr_match #(.ID_W(ID_W), .MODEL_W(MODEL_W)) u_match (
        .dest_mode  (dest_mode),
        .dest_field (dest_field),
        .shorthand  (shorthand),
        .sender_id  (sender_id),
        .node_id    (node_id),
        .logical_id (logical_id),
        .fmt_model  (fmt_model),
        .hit        (hit)
    );

    ipi_cmd_check #(.LOWPRI_SEND_OK(LOWPRI_SEND_OK)) u_check (
        .shorthand  (shorthand),
        .deliv_mode (deliv_mode),
        .level      (level),
        .bad        (bad),
        .is_lowpri  (is_lowpri)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (msg_valid)  state_d = ST_REPORT;
            ST_REPORT: if (!msg_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= 1'b0;
            lp_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (msg_valid) begin
                acc_q <= hit && !bad;
                lp_q  <= hit && !bad && is_lowpri;
                err_q <= bad;
            end
        end
    end

    always_comb begin
        accept    = 1'b0;
        lowpri_ok = 1'b0;
        cmd_err   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REPORT: begin
                accept    = acc_q;
                lowpri_ok = lp_q;
                cmd_err   = err_q;
            end
        endcase
    end

endmodule

// File: rtl/ipi_dest_decoder_chk.sv
module ipi_dest_decoder_chk #(
    parameter int ID_W    = 8,
    parameter int MODEL_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic               dest_mode,
    input logic [ID_W-1:0]    dest_field,
    input logic [1:0]         shorthand,
    input logic [2:0]         deliv_mode,
    input logic               level,
    input logic [ID_W-1:0]    sender_id,
    input logic [ID_W-1:0]    node_id,
    input logic [ID_W-1:0]    logical_id,
    input logic [MODEL_W-1:0] fmt_model,
    input logic               accept,
    input logic               lowpri_ok,
    input logic               cmd_err
);
    // R1
    no_stray_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || lowpri_ok || cmd_err) |-> $past(msg_valid));

    // R12
    no_accept_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!accept && !lowpri_ok));

    // R11
    lowpri_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lowpri_ok |-> accept);

    // R6
    all_shorthand_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && shorthand == 2'b10 && deliv_mode == 3'b000 && level) |=> accept);

    // R9
    others_smi_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && shorthand == 2'b11 && (deliv_mode == 3'b010 || deliv_mode == 3'b110))
        |=> cmd_err);

    // R10
    reserved_mode_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && deliv_mode[1:0] == 2'b11) |=> cmd_err);

    // R2
    phys_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && shorthand == 2'b00 && !dest_mode && dest_field == {ID_W{1'b1}} &&
         deliv_mode == 3'b100 && level) |=> accept);

endmodule

bind ipi_dest_decoder ipi_dest_decoder_chk #(.ID_W(ID_W), .MODEL_W(MODEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .dest_mode  (dest_mode),
    .dest_field (dest_field),
    .shorthand  (shorthand),
    .deliv_mode (deliv_mode),
    .level      (level),
    .sender_id  (sender_id),
    .node_id    (node_id),
    .logical_id (logical_id),
    .fmt_model  (fmt_model),
    .accept     (accept),
    .lowpri_ok  (lowpri_ok),
    .cmd_err    (cmd_err)
);

// File: tb/tb_ipi_dest_decoder.sv
module tb_ipi_dest_decoder;

    typedef struct packed {
        logic [7:0] req;
        logic       dm;
        logic [7:0] dest;
        logic [1:0] sh;
        logic [2:0] mode;
        logic       lvl;
        logic [7:0] sender;
        logic [7:0] node;
        logic [7:0] lid;
        logic [3:0] model;
        logic       e_acc;
        logic       e_lp;
        logic       e_err;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{8'd2,  1'b0, 8'h12, 2'b00, 3'd0, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b1, 1'b0, 1'b0}, // R2 id match
        '{8'd2,  1'b0, 8'h13, 2'b00, 3'd0, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b0, 1'b0, 1'b0}, // R2 miss
        '{8'd2,  1'b0, 8'hFF, 2'b00, 3'd4, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b1, 1'b0, 1'b0}, // R2 broadcast
        '{8'd3,  1'b1, 8'h05, 2'b00, 3'd0, 1'b1, 8'h03, 8'h12, 8'h04, 4'hF, 1'b1, 1'b0, 1'b0}, // R3 flat hit
        '{8'd3,  1'b1, 8'h0A, 2'b00, 3'd0, 1'b1, 8'h03, 8'h12, 8'h04, 4'hF, 1'b0, 1'b0, 1'b0}, // R3 flat miss
        '{8'd4,  1'b1, 8'h31, 2'b00, 3'd0, 1'b1, 8'h03, 8'h12, 8'h33, 4'h0, 1'b1, 1'b0, 1'b0}, // R4 cluster hit
        '{8'd4,  1'b1, 8'h21, 2'b00, 3'd0, 1'b1, 8'h03, 8'h12, 8'h33, 4'h0, 1'b0, 1'b0, 1'b0}, // R4 wrong cluster
        '{8'd4,  1'b1, 8'h34, 2'b00, 3'd0, 1'b1, 8'h03, 8'h12, 8'h33, 4'h0, 1'b0, 1'b0, 1'b0}, // R4 no member bit
        '{8'd4,  1'b1, 8'hFF, 2'b00, 3'd0, 1'b1, 8'h03, 8'h12, 8'hFF, 4'h5, 1'b0, 1'b0, 1'b0}, // R4 undefined model
        '{8'd5,  1'b0, 8'h00, 2'b01, 3'd0, 1'b1, 8'h12, 8'h12, 8'h00, 4'hF, 1'b1, 1'b0, 1'b0}, // R5 self
        '{8'd5,  1'b0, 8'h12, 2'b01, 3'd0, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b0, 1'b0, 1'b0}, // R5 not self
        '{8'd6,  1'b1, 8'h00, 2'b10, 3'd0, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b1, 1'b0, 1'b0}, // R6 all
        '{8'd7,  1'b0, 8'h00, 2'b11, 3'd0, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b1, 1'b0, 1'b0}, // R7 other node
        '{8'd7,  1'b0, 8'h12, 2'b11, 3'd0, 1'b1, 8'h12, 8'h12, 8'h00, 4'hF, 1'b0, 1'b0, 1'b0}, // R7 sender itself
        '{8'd9,  1'b0, 8'h00, 2'b11, 3'd2, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b0, 1'b0, 1'b1}, // R9 SMI
        '{8'd9,  1'b0, 8'h00, 2'b11, 3'd6, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b0, 1'b0, 1'b1}, // R9 Start-Up
        '{8'd9,  1'b0, 8'h00, 2'b10, 3'd2, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b1, 1'b0, 1'b0}, // R9 SMI to all
        '{8'd8,  1'b0, 8'h12, 2'b00, 3'd5, 1'b0, 8'h03, 8'h12, 8'h00, 4'hF, 1'b1, 1'b0, 1'b0}, // R8 INIT deassert
        '{8'd8,  1'b0, 8'h12, 2'b00, 3'd0, 1'b0, 8'h03, 8'h12, 8'h00, 4'hF, 1'b0, 1'b0, 1'b1}, // R8 fixed level 0
        '{8'd12, 1'b0, 8'h12, 2'b00, 3'd4, 1'b0, 8'h03, 8'h12, 8'h00, 4'hF, 1'b0, 1'b0, 1'b1}, // R12 NMI level 0
        '{8'd10, 1'b0, 8'h12, 2'b00, 3'd3, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b0, 1'b0, 1'b1}, // R10 code 3
        '{8'd10, 1'b0, 8'h00, 2'b10, 3'd7, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b0, 1'b0, 1'b1}, // R10 code 7
        '{8'd11, 1'b0, 8'h12, 2'b00, 3'd1, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b1, 1'b1, 1'b0}, // R11 eligible
        '{8'd11, 1'b0, 8'h13, 2'b00, 3'd1, 1'b1, 8'h03, 8'h12, 8'h00, 4'hF, 1'b0, 1'b0, 1'b0}  // R11 not addressed
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       msg_valid, dest_mode, level;
    logic [7:0] dest_field, sender_id, node_id, logical_id;
    logic [1:0] shorthand;
    logic [2:0] deliv_mode;
    logic [3:0] fmt_model;
    logic       accept, lowpri_ok, cmd_err;
    logic       accept_n, lowpri_ok_n, cmd_err_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ipi_dest_decoder dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .dest_mode(dest_mode),
        .dest_field(dest_field), .shorthand(shorthand), .deliv_mode(deliv_mode),
        .level(level), .sender_id(sender_id), .node_id(node_id),
        .logical_id(logical_id), .fmt_model(fmt_model),
        .accept(accept), .lowpri_ok(lowpri_ok), .cmd_err(cmd_err)
    );

    ipi_dest_decoder #(.LOWPRI_SEND_OK(1'b0)) dut_nolp (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .dest_mode(dest_mode),
        .dest_field(dest_field), .shorthand(shorthand), .deliv_mode(deliv_mode),
        .level(level), .sender_id(sender_id), .node_id(node_id),
        .logical_id(logical_id), .fmt_model(fmt_model),
        .accept(accept_n), .lowpri_ok(lowpri_ok_n), .cmd_err(cmd_err_n)
    );

    task automatic check3(input string tag, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {accept,lowpri_ok,cmd_err} got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        msg_valid  = 1'b1;
        dest_mode  = v.dm;
        dest_field = v.dest;
        shorthand  = v.sh;
        deliv_mode = v.mode;
        level      = v.lvl;
        sender_id  = v.sender;
        node_id    = v.node;
        logical_id = v.lid;
        fmt_model  = v.model;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(VECS[0]);
        msg_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check3("R1 reset", {accept, lowpri_ok, cmd_err}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R1 idle", {accept, lowpri_ok, cmd_err}, 3'b000);

        // table, driven back to back
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check3($sformatf("R%0d vector %0d", VECS[i].req, i),
                   {accept, lowpri_ok, cmd_err},
                   {VECS[i].e_acc, VECS[i].e_lp, VECS[i].e_err});
        end

        // R1: strobe dropped, flags clear next cycle
        msg_valid = 1'b0;
        @(negedge clk);
        check3("R1 no strobe", {accept, lowpri_ok, cmd_err}, 3'b000);

        // R1: result appears exactly one clock after an isolated strobe
        drive(VECS[0]);
        @(posedge clk);
        #1;
        msg_valid = 1'b0;
        check3("R1 one clock", {accept, lowpri_ok, cmd_err}, 3'b100);
        @(negedge clk);
        @(negedge clk);
        check3("R1 pulse ends", {accept, lowpri_ok, cmd_err}, 3'b000);

        // R11: node built without lowest-priority permission
        drive(VECS[22]);
        @(negedge clk);
        check3("R11 lowpri disallowed", {accept_n, lowpri_ok_n, cmd_err_n}, 3'b001);
        check3("R11 lowpri allowed", {accept, lowpri_ok, cmd_err}, 3'b110);

        // R12: error under a broadcast shorthand still blocks accept
        drive(VECS[11]);
        level = 1'b0;
        @(negedge clk);
        check3("R12 all with level 0", {accept, lowpri_ok, cmd_err}, 3'b001);

        // R8: INIT deassert under all-excluding-self on another node
        drive(VECS[12]);
        deliv_mode = 3'd5;
        level = 1'b0;
        @(negedge clk);
        check3("R8 INIT deassert to others", {accept, lowpri_ok, cmd_err}, 3'b100);

        // R1: reset mid-report clears flags
        drive(VECS[0]);
        @(negedge clk);
        rst_n = 1'b0;
        msg_valid = 1'b0;
        @(negedge clk);
        check3("R1 reset clears", {accept, lowpri_ok, cmd_err}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule